// File: doc/BRIEF.md
# Block-Boundary Access Splitter

This block turns one functional memory access (a read or a write, given as a byte address, a byte length and a starting offset into the requester's data buffer) into a sequence of pieces, none of which spans two cache blocks. The first piece runs from the start address up to the next block boundary, or to the end of the access if that comes sooner. Each later piece starts exactly on a boundary. Every piece carries the buffer offset of its first byte.

Each piece is first presented to a translation port. The port is picked by the requester ID: one ID value addresses the dispatcher's translator and the lower values address the translator of the matching compute unit. Once translation acknowledges, the same piece is presented to the memory port. Only after memory acknowledges does the next piece start, so pieces complete in ascending address order. Commands other than read and write, and out-of-range requester IDs, are rejected with a one-cycle error pulse and produce no piece.

Top module: `acc_split`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `xlat_valid`, `mem_valid`, `done` and `err` are 0.
- R2: Every piece lies inside one aligned block of `BLK_BYTES` (default 64) bytes. Its size is the smaller of the bytes still left and the bytes from its address up to the next multiple of `BLK_BYTES`, so only the first piece can start off a boundary.
- R3: Piece addresses are consecutive. The offset of a piece equals `req_ofs` plus the sizes of all earlier pieces (modulo 2^`LEN_W`), so a second piece's offset exceeds the first's by the first piece's length.
- R4: `req_cmd` 2'b01 is a read and 2'b10 is a write. Any other value accepted at the request port makes `err` high for exactly the next cycle, with no piece and no `done`.
- R5: A piece appears on the translation port before the memory port, and `mem_valid` rises only after `xlat_ack`. The mode bits `xlat_write` and `mem_write` are 1 for a write and 0 for a read.
- R6: `xlat_sel` is one-hot with `N_CU+1` bits. `req_id` equal to `N_CU` sets bit `N_CU` (dispatcher), and `req_id` below `N_CU` sets bit `req_id`. A `req_id` above `N_CU` is rejected as in R4.
- R7: The `req_quiet` error-suppression flag is copied to `xlat_quiet` and `mem_quiet` for every piece of that access.
- R8: The next piece is offered on the translation port in the cycle after `mem_ack`. In the cycle after the last piece's `mem_ack`, `done` is high for one cycle and the block is idle again.
- R9: While `xlat_valid` or `mem_valid` is high and not acknowledged, it stays high and the fields on that port do not change.
- R10: A valid request with `req_len` 0 produces no piece and pulses `done` in the next cycle.
- R11: `req_ready` is 1 only while idle. A `req_valid` seen while busy is ignored and does not alter the pieces of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_cmd | input | 2 | 01 read, 10 write, other values invalid |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte length |
| req_ofs | input | LEN_W | Buffer offset of the first byte |
| req_id | input | ID_W | Requester ID; N_CU is the dispatcher |
| req_quiet | input | 1 | Suppress functional errors for this access |
| xlat_valid | output | 1 | Piece offered to translation |
| xlat_ack | input | 1 | Translation accepted the piece |
| xlat_sel | output | N_CU+1 | One-hot translation port select |
| xlat_addr | output | ADDR_W | Piece address for translation |
| xlat_write | output | 1 | Translation mode: 1 write, 0 read |
| xlat_quiet | output | 1 | Error-suppression flag of the piece |
| mem_valid | output | 1 | Piece offered to memory |
| mem_ack | input | 1 | Memory completed the piece |
| mem_addr | output | ADDR_W | Piece address |
| mem_size | output | LEN_W | Piece size in bytes |
| mem_ofs | output | LEN_W | Buffer offset of the piece |
| mem_write | output | 1 | 1 write, 0 read |
| mem_quiet | output | 1 | Error-suppression flag of the piece |
| done | output | 1 | One-cycle pulse at the end of an access |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench aims at the boundary arithmetic: an access that starts a few bytes short of a boundary, one ending exactly on a boundary, a single byte in the last slot of a block and multi-block runs. A design that cut at unaligned points or sized the first piece as a full block would show a wrong size, address or offset on the second piece. It also drives the rejected command codes, an ID above the dispatcher value and a zero length, where a faulty design would issue a stray piece or miss the error or done pulse. A new request is injected in the middle of an access, and acknowledgements are held back for several cycles. A design that dropped the valid, moved fields while waiting or accepted the intruding request would change the piece stream.

// File: rtl/acc_split_pkg.sv
package acc_split_pkg;

    localparam logic [1:0] CMD_RD = 2'b01;
    localparam logic [1:0] CMD_WR = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XLAT = 2'd1,
        ST_MEM  = 2'd2
    } split_st_e;

endpackage

// File: rtl/acc_split_piece.sv
// Size of the current piece: bytes left, clipped at the next block boundary.
module acc_split_piece #(
    parameter int LEN_W     = 12,
    parameter int BLK_BYTES = 64,
    localparam int OFF_W    = $clog2(BLK_BYTES)
) (
    input  logic [OFF_W-1:0] addr_lo,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] size,
    output logic             last
);
    logic [LEN_W-1:0] room;

    always_comb begin
        room = LEN_W'(BLK_BYTES) - LEN_W'(addr_lo);
        size = (remain < room) ? remain : room;
        last = (remain == size);
    end
endmodule

// File: rtl/acc_split_route.sv
// Requester ID to one-hot translation port select.
module acc_split_route #(
    parameter int N_CU = 4,
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0] id,
    output logic [N_CU:0]   sel,
    output logic            id_ok
);
    for (genvar g = 0; g < N_CU; g++) begin : g_cu
        assign sel[g] = (id == ID_W'(g));
    end
    assign sel[N_CU] = (id == ID_W'(N_CU));
    assign id_ok     = (id <= ID_W'(N_CU));
endmodule

// File: rtl/acc_split.sv
module acc_split
    import acc_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 12,
    parameter int BLK_BYTES = 64,
    parameter int N_CU      = 4,
    parameter int ID_W      = $clog2(N_CU + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LEN_W-1:0]  req_ofs,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_quiet,
    output logic              xlat_valid,
    input  logic              xlat_ack,
    output logic [N_CU:0]     xlat_sel,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              xlat_write,
    output logic              xlat_quiet,
    output logic              mem_valid,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_size,
    output logic [LEN_W-1:0]  mem_ofs,
    output logic              mem_write,
    output logic              mem_quiet,
    output logic              done,
    output logic              err
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    typedef struct packed {
        split_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  ofs;
        logic              wr;
        logic              quiet;
        logic [N_CU:0]     sel;
        logic              done;
        logic              err;
    } split_t;

    split_t r_d, r_q;

    logic [N_CU:0]    id_sel;
    logic             id_ok;
    logic             cmd_ok;
    logic [LEN_W-1:0] piece_size;
    logic             piece_last;

    acc_split_route #(.N_CU(N_CU), .ID_W(ID_W)) u_route (
        .id    (req_id),
        .sel   (id_sel),
        .id_ok (id_ok)
    );

    acc_split_piece #(.LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_piece (
        .addr_lo (r_q.addr[OFF_W-1:0]),
        .remain  (r_q.remain),
        .size    (piece_size),
        .last    (piece_last)
    );

    assign cmd_ok = (req_cmd == CMD_RD) || (req_cmd == CMD_WR);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!cmd_ok || !id_ok) begin
                        r_d.err = 1'b1;
                    end else if (req_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st     = ST_XLAT;
                        r_d.addr   = req_addr;
                        r_d.remain = req_len;
                        r_d.ofs    = req_ofs;
                        r_d.wr     = (req_cmd == CMD_WR);
                        r_d.quiet  = req_quiet;
                        r_d.sel    = id_sel;
                    end
                end
            end
            ST_XLAT: begin
                if (xlat_ack) r_d.st = ST_MEM;
            end
            ST_MEM: begin
                if (mem_ack) begin
                    if (piece_last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st     = ST_XLAT;
                        r_d.addr   = r_q.addr + ADDR_W'(piece_size);
                        r_d.remain = r_q.remain - piece_size;
                        r_d.ofs    = r_q.ofs + piece_size;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign xlat_valid = (r_q.st == ST_XLAT);
    assign xlat_sel   = r_q.sel;
    assign xlat_addr  = r_q.addr;
    assign xlat_write = r_q.wr;
    assign xlat_quiet = r_q.quiet;
    assign mem_valid  = (r_q.st == ST_MEM);
    assign mem_addr   = r_q.addr;
    assign mem_size   = piece_size;
    assign mem_ofs    = r_q.ofs;
    assign mem_write  = r_q.wr;
    assign mem_quiet  = r_q.quiet;
    assign done       = r_q.done;
    assign err        = r_q.err;
endmodule

// File: rtl/acc_split_chk.sv
module acc_split_chk #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 12,
    parameter int BLK_BYTES = 64,
    parameter int N_CU      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_valid,
    input logic              xlat_ack,
    input logic [N_CU:0]     xlat_sel,
    input logic [ADDR_W-1:0] xlat_addr,
    input logic              mem_valid,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_size,
    input logic              done,
    input logic              err
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    logic [LEN_W:0] end_in_blk;
    assign end_in_blk = (LEN_W+1)'(mem_addr[OFF_W-1:0]) + (LEN_W+1)'(mem_size);

    a_r2_piece_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_size != '0) && (end_in_blk <= (LEN_W+1)'(BLK_BYTES)));

    a_r5_one_port_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlat_valid && mem_valid));

    a_r5_mem_after_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(xlat_valid && xlat_ack));

    a_r4_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !xlat_valid && !mem_valid && !done);

    a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_valid |-> $countones(xlat_sel) == 1);

    a_r9_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_valid && !xlat_ack |=> xlat_valid && $stable(xlat_addr) && $stable(xlat_sel));

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_size));

    a_r8_serial: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ack |=> !mem_valid && (xlat_valid || done));
endmodule

bind acc_split acc_split_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES), .N_CU(N_CU)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .xlat_valid(xlat_valid), .xlat_ack(xlat_ack), .xlat_sel(xlat_sel),
    .xlat_addr(xlat_addr), .mem_valid(mem_valid), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_size(mem_size), .done(done), .err(err)
);

// File: tb/acc_split_bench.sv
module acc_split_bench;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int BLK    = 64;
    localparam int N_CU   = 4;
    localparam int ID_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_quiet = 1'b0;
    logic req_ready;
    logic [1:0] req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0, req_ofs = '0;
    logic [ID_W-1:0] req_id = '0;
    logic xlat_valid, xlat_write, xlat_quiet;
    logic xlat_ack = 1'b0, mem_ack = 1'b0;
    logic [N_CU:0] xlat_sel;
    logic [ADDR_W-1:0] xlat_addr, mem_addr;
    logic mem_valid, mem_write, mem_quiet, done, err;
    logic [LEN_W-1:0] mem_size, mem_ofs;

    int n_run = 0, n_fail = 0;
    bit poke = 1'b0;

    always #10 clk = ~clk;

    acc_split u_acc_split (.*);

    typedef struct packed {
        logic [1:0]  cmd;
        logic [31:0] addr;
        logic [11:0] len;
        logic [11:0] ofs;
        logic [2:0]  id;
        logic        quiet;
        logic [3:0]  stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 32'h0000_1000, 12'd64,  12'd0,  3'd0, 1'b0, 4'd0},
        '{2'b10, 32'h0000_103C, 12'd10,  12'd0,  3'd4, 1'b1, 4'd1},
        '{2'b01, 32'h0000_2005, 12'd200, 12'd16, 3'd2, 1'b0, 4'd3},
        '{2'b10, 32'h0000_007F, 12'd1,   12'd5,  3'd3, 1'b1, 4'd0},
        '{2'b01, 32'h0000_0040, 12'd128, 12'd0,  3'd1, 1'b0, 4'd2},
        '{2'b10, 32'hFFFF_FFF0, 12'd16,  12'd7,  3'd0, 1'b0, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_xlat();
        for (int i = 0; i < 40 && !xlat_valid; i++) @(negedge clk);
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_cmd = v.cmd; req_addr = v.addr; req_len = v.len;
        req_ofs = v.ofs; req_id = v.id; req_quiet = v.quiet;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] a;
        int rem, off, room, sz;
        logic [N_CU:0] exp_sel;
        issue(v);
        a = v.addr; rem = int'(v.len); off = int'(v.ofs);
        exp_sel = '0; exp_sel[v.id] = 1'b1;
        while (rem > 0) begin
            room = BLK - int'(a % BLK);
            sz = (rem < room) ? rem : room;
            wait_xlat();
            chk(xlat_valid == 1'b1, "R8 piece offered", xlat_valid, 1);
            chk(xlat_addr == a, "R3 xlat address", xlat_addr, a);
            chk(xlat_sel == exp_sel, "R6 port select", xlat_sel, exp_sel);
            chk(xlat_write == (v.cmd == 2'b10), "R5 xlat mode", xlat_write, v.cmd == 2'b10);
            chk(xlat_quiet == v.quiet, "R7 xlat quiet", xlat_quiet, v.quiet);
            chk(mem_valid == 1'b0, "R5 memory waits for translation", mem_valid, 0);
            for (int s = 0; s < int'(v.stall); s++) begin
                if (poke && s == 0) begin
                    req_valid = 1'b1; req_cmd = 2'b01; req_addr = 32'h0; req_len = 12'd5;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk(xlat_valid && xlat_addr == a, "R9 xlat held", xlat_addr, a);
            end
            xlat_ack = 1'b1;
            @(negedge clk);
            xlat_ack = 1'b0;
            chk(mem_valid == 1'b1 && xlat_valid == 1'b0, "R5 memory after ack", mem_valid, 1);
            chk(mem_addr == a, "R2 piece address", mem_addr, a);
            chk(int'(mem_size) == sz, "R2 piece size", mem_size, sz);
            chk(int'(mem_ofs) == (off % 4096), "R3 piece offset", mem_ofs, off % 4096);
            chk(mem_write == (v.cmd == 2'b10), "R5 mem mode", mem_write, v.cmd == 2'b10);
            chk(mem_quiet == v.quiet, "R7 mem quiet", mem_quiet, v.quiet);
            for (int s = 0; s < int'(v.stall); s++) begin
                @(negedge clk);
                chk(mem_valid && int'(mem_size) == sz, "R9 mem held", mem_size, sz);
            end
            mem_ack = 1'b1;
            @(negedge clk);
            a = a + 32'(sz); rem = rem - sz; off = off + sz;
            if (rem == 0) begin
                chk(done == 1'b1 && req_ready == 1'b1, "R8 done after last piece", done, 1);
            end else begin
                chk(done == 1'b0 && xlat_valid == 1'b1, "R8 next piece follows", xlat_valid, 1);
            end
            mem_ack = 1'b0;
        end
        @(negedge clk);
        chk(done == 1'b0 && xlat_valid == 1'b0, "R8 done is one pulse", done, 0);
    endtask

    task automatic reject(input vec_t v, input string req);
        issue(v);
        chk(err == 1'b1, req, err, 1);
        chk(xlat_valid == 1'b0 && done == 1'b0, req, xlat_valid, 0);
        @(negedge clk);
        chk(err == 1'b0 && xlat_valid == 1'b0, req, err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !xlat_valid && !mem_valid && !done && !err, "R1 reset state",
            {req_ready, xlat_valid, mem_valid, done, err}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !xlat_valid && !mem_valid, "R1 idle after reset", req_ready, 1);

        for (int k = 0; k < 6; k++) run_vec(VECS[k]);

        // R4: invalid command codes
        reject('{2'b00, 32'h100, 12'd8, 12'd0, 3'd0, 1'b0, 4'd0}, "R4 cmd 00 rejected");
        reject('{2'b11, 32'h100, 12'd8, 12'd0, 3'd1, 1'b0, 4'd0}, "R4 cmd 11 rejected");
        // R6: ID above dispatcher value
        reject('{2'b01, 32'h100, 12'd8, 12'd0, 3'd5, 1'b0, 4'd0}, "R6 id above N rejected");

        // R10: zero length
        issue('{2'b10, 32'h200, 12'd0, 12'd0, 3'd0, 1'b0, 4'd0});
        chk(done == 1'b1 && xlat_valid == 1'b0 && err == 1'b0, "R10 zero length done", done, 1);
        @(negedge clk);
        chk(done == 1'b0 && xlat_valid == 1'b0, "R10 no piece", xlat_valid, 0);

        // R11: request while busy is ignored
        poke = 1'b1;
        run_vec('{2'b10, 32'h0000_30F8, 12'd20, 12'd3, 3'd4, 1'b0, 4'd2});
        poke = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(xlat_valid == 1'b0, "R11 busy request ignored", xlat_valid, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule